// File: doc/BRIEF.md
# Configurable Synchronous Serial Word Receiver

This block takes a serial bit stream that arrives with its own bit clock and a frame sync strobe, assembles the bits into parallel words and queues them in a two-entry buffer for a host to read. The serial clock, frame sync and data lines are sampled by the block's system clock, which must run at least four times faster than the serial clock. The block acts only on the serial clock edge that the configuration selects.

Configuration inputs select the following options. The sampling edge can be rising or falling. The frame sync can be active high or active low. Framing can be early or late. Frame syncs can be required for every word, or the block can run back-to-back words after one initial sync. The bit order can be MSB-first or LSB-first. The word length can be 3 to 32 bits. The block can also combine two 16-bit words into one 32-bit buffer entry. The host reads the oldest word and pops it with a one-cycle read strobe. A two-bit code reports how full the buffer is, and a sticky flag records lost words. All configuration inputs are expected to change only while the enable input is low.

Top module: `ser_rx`

## Requirements
- R1: When `cfg_rise_edge` is 1, data and frame sync are sampled on rising edges of `ser_clk`. When it is 0, they are sampled on falling edges. Edges of the opposite direction have no effect.
- R2: When `cfg_fs_active_low` is 0, the frame sync is active when `ser_fs` is high. When it is 1, the frame sync is active when `ser_fs` is low.
- R3: When `cfg_late_fs` is 1, the bit sampled together with an active frame sync is the first bit of the word. When it is 0, the first bit is the one sampled at the next selected edge after the frame sync.
- R4: When `cfg_fs_required` is 1, each word needs its own frame sync, and bits that arrive without a frame sync are dropped. When it is 0, the first word still needs a frame sync, and each later word starts at the selected edge right after the previous word's last bit.
- R5: When `cfg_lsb_first` is 0, the first received bit is the most significant bit of the word. When it is 1, the first received bit is bit 0.
- R6: A word has `cfg_len_m1`+1 bits, and lengths from 3 to 32 are supported. Each word is right-justified in `rd_data`, and all bits above the word are zero.
- R7: When `cfg_pack` is 1, two consecutive words (each truncated to 16 bits) form one buffer entry. The first word goes in bits 15:0 and the second word goes in bits 31:16. No entry is written after only the first of the two words.
- R8: `rx_status` is 2'b00 when the buffer is empty, 2'b10 when it holds one entry, and 2'b11 when it holds two entries.
- R9: If a new entry arrives while the buffer is full and no read happens in that cycle, the new entry is discarded, the stored entries are kept, and `rx_overflow` is set. The flag stays set until the block is disabled.
- R10: While `cfg_en` is 0, the buffer is empty, `rx_overflow` is 0, and both the partial word and the stored first half of a packed pair are discarded.
- R11: `rd_data` shows the oldest entry, or zero when the buffer is empty. A cycle with `rd_en` high removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Receiver enable; low clears all state |
| cfg_rise_edge | input | 1 | 1: sample on rising serial clock edge, 0: falling |
| cfg_fs_active_low | input | 1 | 1: frame sync active low, 0: active high |
| cfg_late_fs | input | 1 | 1: late framing, 0: early framing |
| cfg_fs_required | input | 1 | 1: frame sync needed per word, 0: back-to-back words |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_pack | input | 1 | 1: pack two 16-bit words per entry |
| cfg_len_m1 | input | 5 | Word length minus one |
| ser_clk | input | 1 | Serial bit clock |
| ser_fs | input | 1 | Serial frame sync |
| ser_data | input | 1 | Serial data |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 32 | Oldest entry, zero when empty |
| rx_status | output | 2 | Buffer fill code |
| rx_overflow | output | 1 | Sticky overflow flag |

## Verification
A selected serial edge is registered at one system clock edge. The bit is taken into the word at the next edge. A completed word reaches the buffer, `rx_status` and `rx_overflow` at the third edge after the serial line changes. A read strobe takes effect on `rd_data` one edge after it is seen. The bench holds data steady for two system cycles on each side of the selected serial edge. It changes data only away from that edge, so that sampling on the wrong edge picks up the previous bit. It waits eight cycles after the last bit of a word before it samples outputs, and it drives and samples on the falling edge of the system clock.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LEN_W   = $clog2(WORD_W);
    localparam int unsigned CNT_W   = LEN_W + 1;
    localparam int unsigned HALF_W  = WORD_W / 2;
    localparam int unsigned BUF_DEPTH = 2;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_ARMED = 2'd1,
        FR_SHIFT = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    // Place one received bit into the word being assembled.
    function automatic logic [WORD_W-1:0] put_bit(
        input logic [WORD_W-1:0] acc,
        input logic              b,
        input logic [CNT_W-1:0]  idx,
        input logic              lsb_first
    );
        logic [WORD_W-1:0] one;
        one = {{(WORD_W-1){1'b0}}, b};
        if (lsb_first)
            return acc | (one << idx[LEN_W-1:0]);
        else
            return {acc[WORD_W-2:0], b};
    endfunction

    function automatic logic [1:0] fill_code(input logic is_empty, input logic is_full);
        if (is_empty)     return 2'b00;
        else if (is_full) return 2'b11;
        else              return 2'b10;
    endfunction

endpackage

// File: rtl/ser_rx_sampler.sv
module ser_rx_sampler (
    input  logic clk,
    input  logic rst,
    input  logic rise_edge,
    input  logic fs_active_low,
    input  logic ser_clk,
    input  logic ser_fs,
    input  logic ser_data,
    output logic bit_stb,
    output logic bit_val,
    output logic fs_active
);
    logic sclk_q, sclk_q2, fs_q, data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sclk_q2 <= 1'b0;
            fs_q    <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            sclk_q  <= ser_clk;
            sclk_q2 <= sclk_q;
            fs_q    <= ser_fs;
            data_q  <= ser_data;
        end
    end

    always_comb begin
        bit_stb   = rise_edge ? (sclk_q & ~sclk_q2) : (~sclk_q & sclk_q2);
        bit_val   = data_q;
        fs_active = fs_q ^ fs_active_low;
    end

endmodule

// File: rtl/ser_rx_framer.sv
module ser_rx_framer
    import ser_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             late_fs,
    input  logic             fs_required,
    input  logic             lsb_first,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             fs_active,
    output rx_word_t         word_o
);
    frame_state_e      state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nxt;
    logic              last_bit;

    always_comb begin
        acc_nxt  = put_bit(acc_q, bit_val, cnt_q, lsb_first);
        last_bit = (cnt_q == {1'b0, len_m1});
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q      <= FR_IDLE;
            cnt_q        <= '0;
            acc_q        <= '0;
            word_o.valid <= 1'b0;
            word_o.data  <= '0;
        end else begin
            word_o.valid <= 1'b0;
            if (bit_stb) begin
                unique case (state_q)
                    FR_IDLE: begin
                        if (fs_active) begin
                            if (late_fs) begin
                                acc_q   <= put_bit('0, bit_val, '0, lsb_first);
                                cnt_q   <= CNT_W'(1);
                                state_q <= FR_SHIFT;
                            end else begin
                                state_q <= FR_ARMED;
                            end
                        end
                    end
                    FR_ARMED: begin
                        acc_q   <= put_bit('0, bit_val, '0, lsb_first);
                        cnt_q   <= CNT_W'(1);
                        state_q <= FR_SHIFT;
                    end
                    FR_SHIFT: begin
                        if (last_bit) begin
                            word_o.valid <= 1'b1;
                            word_o.data  <= acc_nxt;
                            acc_q        <= '0;
                            cnt_q        <= '0;
                            state_q      <= fs_required ? FR_IDLE : FR_ARMED;
                        end else begin
                            acc_q <= acc_nxt;
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    default: state_q <= FR_IDLE;
                endcase
            end
        end
    end

    // R6: completed words carry nothing above the configured length
    p_zero_upper_r6: assert property (@(posedge clk) disable iff (rst)
        word_o.valid |-> ((word_o.data >> ({1'b0, len_m1} + CNT_W'(1))) == '0));

    // R6: a completed word is a single-cycle event
    p_word_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        word_o.valid |=> !word_o.valid);

endmodule

// File: rtl/ser_rx_packer.sv
module ser_rx_packer
    import ser_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     pack,
    input  rx_word_t word_i,
    output rx_word_t word_o
);
    logic              half_q;
    logic [HALF_W-1:0] low_q;

    always_comb begin
        if (pack) begin
            word_o.valid = word_i.valid && half_q;
            word_o.data  = {word_i.data[HALF_W-1:0], low_q};
        end else begin
            word_o = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            half_q <= 1'b0;
            low_q  <= '0;
        end else if (pack && word_i.valid) begin
            if (!half_q) low_q <= word_i.data[HALF_W-1:0];
            half_q <= ~half_q;
        end
    end

    // R7: after a packed entry is emitted, the next word starts a new pair
    p_pair_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (en && pack && word_o.valid) |=> !half_q);

endmodule

// File: rtl/ser_rx_buffer.sv
module ser_rx_buffer
    import ser_rx_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_DEPTH,
    parameter int unsigned DW    = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic [1:0]    status,
    output logic          overflow
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          empty, full, pop, accept, drop;

    always_comb begin
        empty  = (cnt_q == '0);
        full   = (cnt_q == CW'(DEPTH));
        pop    = pop_req && !empty;
        accept = push && (!full || pop);
        drop   = push && full && !pop;
        head   = empty ? '0 : mem_q[rd_q];
        status = fill_code(empty, full);
    end

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wr_q     <= '0;
            rd_q     <= '0;
            cnt_q    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_q <= bump(wr_q);
            if (pop)    rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(accept) - CW'(pop);
            if (drop) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[wr_q] <= push_data;
    end

    // R9: overflow stays set while enabled
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overflow && en) |=> overflow);

    // R9: a dropped entry leaves the buffer full and flags overflow
    p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (en && push && full && !pop_req) |=> (overflow && status == 2'b11));

    // R10: disabling empties the buffer and clears the flag
    p_disable_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (status == 2'b00 && !overflow));

endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_rise_edge,
    input  logic              cfg_fs_active_low,
    input  logic              cfg_late_fs,
    input  logic              cfg_fs_required,
    input  logic              cfg_lsb_first,
    input  logic              cfg_pack,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic              ser_clk,
    input  logic              ser_fs,
    input  logic              ser_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        rx_status,
    output logic              rx_overflow
);
    logic     bit_stb, bit_val, fs_active;
    rx_word_t raw_word, packed_word;

    ser_rx_sampler u_sampler (
        .clk          (clk),
        .rst          (rst),
        .rise_edge    (cfg_rise_edge),
        .fs_active_low(cfg_fs_active_low),
        .ser_clk      (ser_clk),
        .ser_fs       (ser_fs),
        .ser_data     (ser_data),
        .bit_stb      (bit_stb),
        .bit_val      (bit_val),
        .fs_active    (fs_active)
    );

    ser_rx_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_en),
        .late_fs    (cfg_late_fs),
        .fs_required(cfg_fs_required),
        .lsb_first  (cfg_lsb_first),
        .len_m1     (cfg_len_m1),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .fs_active  (fs_active),
        .word_o     (raw_word)
    );

    ser_rx_packer u_packer (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg_en),
        .pack  (cfg_pack),
        .word_i(raw_word),
        .word_o(packed_word)
    );

    ser_rx_buffer #(.DEPTH(BUF_DEPTH), .DW(WORD_W)) u_buffer (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_en),
        .push     (packed_word.valid),
        .push_data(packed_word.data),
        .pop_req  (rd_en),
        .head     (rd_data),
        .status   (rx_status),
        .overflow (rx_overflow)
    );

    // R8: an entry written into an empty buffer moves the code to partially full
    p_first_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && packed_word.valid && rx_status == 2'b00) |=> (rx_status == 2'b10));

endmodule

// File: tb/ser_rx_tb_top.sv
module ser_rx_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        cfg_rise_edge = 1'b1;
    logic        cfg_fs_active_low = 1'b0;
    logic        cfg_late_fs = 1'b1;
    logic        cfg_fs_required = 1'b1;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_pack = 1'b0;
    logic [4:0]  cfg_len_m1 = 5'd7;
    logic        ser_clk = 1'b1;
    logic        ser_fs = 1'b0;
    logic        ser_data = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  rx_status;
    logic        rx_overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    ser_rx dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_rise_edge(cfg_rise_edge),
        .cfg_fs_active_low(cfg_fs_active_low), .cfg_late_fs(cfg_late_fs),
        .cfg_fs_required(cfg_fs_required), .cfg_lsb_first(cfg_lsb_first),
        .cfg_pack(cfg_pack), .cfg_len_m1(cfg_len_m1), .ser_clk(ser_clk),
        .ser_fs(ser_fs), .ser_data(ser_data), .rd_en(rd_en), .rd_data(rd_data),
        .rx_status(rx_status), .rx_overflow(rx_overflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic fs_level(input logic active);
        return active ^ cfg_fs_active_low;
    endfunction

    // one bit slot: off-edge, data change, selected edge
    task automatic bit_slot(input logic d, input logic fs_on);
        wait_clk(2);
        ser_clk = ~cfg_rise_edge;
        wait_clk(2);
        ser_data = d;
        ser_fs   = fs_level(fs_on);
        wait_clk(2);
        ser_clk = cfg_rise_edge;
    endtask

    task automatic send_word(input logic [31:0] val, input int n, input logic with_fs);
        if (with_fs && !cfg_late_fs) bit_slot(1'b0, 1'b1);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = cfg_lsb_first ? val[i] : val[n-1-i];
            bit_slot(b, with_fs && cfg_late_fs && (i == 0));
        end
        wait_clk(2);
        ser_fs = fs_level(1'b0);
        wait_clk(8);
    endtask

    task automatic setup(input logic rise, input logic fslow, input logic late,
                         input logic req, input logic lsb, input logic pk, input logic [4:0] lm1);
        cfg_en = 1'b0;
        wait_clk(1);
        cfg_rise_edge = rise;
        cfg_fs_active_low = fslow;
        cfg_late_fs = late;
        cfg_fs_required = req;
        cfg_lsb_first = lsb;
        cfg_pack = pk;
        cfg_len_m1 = lm1;
        ser_clk = rise;
        ser_fs = fs_level(1'b0);
        ser_data = 1'b0;
        wait_clk(4);
        cfg_en = 1'b1;
        wait_clk(2);
    endtask

    task automatic pop_one();
        rd_en = 1'b1;
        wait_clk(1);
        rd_en = 1'b0;
        wait_clk(1);
    endtask

    task automatic t_reset();
        check("R8 reset status", 32'(rx_status), 32'h0);
        check("R9 reset overflow", 32'(rx_overflow), 32'h0);
        check("R11 reset rd_data zero", rd_data, 32'h0);
    endtask

    task automatic t_msb_late_rise();
        setup(1, 0, 1, 1, 0, 0, 5'd7);
        send_word(32'hA5, 8, 1);
        check("R1 R3 R5 msb late rising word", rd_data, 32'hA5);
        check("R8 one entry status", 32'(rx_status), 32'h2);
    endtask

    task automatic t_lsb_early_fall_low();
        setup(0, 1, 0, 1, 1, 0, 5'd11);
        send_word(32'h3C5, 12, 1);
        check("R1 R2 R3 R5 lsb early falling active-low word", rd_data, 32'h3C5);
    endtask

    task automatic t_lengths();
        setup(1, 0, 1, 1, 0, 0, 5'd31);
        send_word(32'hDEADBEEF, 32, 1);
        check("R6 32-bit word", rd_data, 32'hDEADBEEF);
        setup(1, 0, 0, 1, 1, 0, 5'd2);
        send_word(32'h6, 3, 1);
        check("R6 3-bit word right-justified", rd_data, 32'h6);
    endtask

    task automatic t_no_fs_dropped();
        setup(1, 0, 1, 1, 0, 0, 5'd7);
        send_word(32'h5A, 8, 0);
        check("R4 bits without frame sync dropped", 32'(rx_status), 32'h0);
        send_word(32'h3C, 8, 1);
        check("R4 next framed word received", rd_data, 32'h3C);
    endtask

    task automatic t_continuous();
        setup(1, 0, 1, 0, 0, 0, 5'd7);
        send_word(32'h12, 8, 1);
        send_word(32'h34, 8, 0);
        check("R4 continuous two entries", 32'(rx_status), 32'h3);
        check("R11 oldest first", rd_data, 32'h12);
        pop_one();
        check("R4 R11 back-to-back word after pop", rd_data, 32'h34);
        check("R8 status after pop", 32'(rx_status), 32'h2);
    endtask

    task automatic t_overflow();
        setup(1, 0, 1, 1, 0, 0, 5'd7);
        send_word(32'h11, 8, 1);
        send_word(32'h22, 8, 1);
        check("R9 no overflow when just full", 32'(rx_overflow), 32'h0);
        send_word(32'h33, 8, 1);
        check("R9 overflow set", 32'(rx_overflow), 32'h1);
        check("R8 full status", 32'(rx_status), 32'h3);
        check("R9 first kept", rd_data, 32'h11);
        pop_one();
        check("R9 second kept, third dropped", rd_data, 32'h22);
        check("R9 overflow sticky after pop", 32'(rx_overflow), 32'h1);
        pop_one();
        check("R11 empty reads zero", rd_data, 32'h0);
        check("R8 empty status", 32'(rx_status), 32'h0);
        check("R9 still sticky when empty", 32'(rx_overflow), 32'h1);
    endtask

    task automatic t_pack();
        setup(1, 0, 1, 1, 0, 1, 5'd15);
        send_word(32'hBEEF, 16, 1);
        check("R7 no entry after first half", 32'(rx_status), 32'h0);
        send_word(32'h1234, 16, 1);
        check("R7 packed entry", rd_data, 32'h1234BEEF);
        check("R7 R8 one packed entry", 32'(rx_status), 32'h2);
    endtask

    task automatic t_disable();
        setup(1, 0, 1, 1, 0, 0, 5'd7);
        send_word(32'h01, 8, 1);
        send_word(32'h02, 8, 1);
        send_word(32'h03, 8, 1);
        cfg_en = 1'b0;
        wait_clk(2);
        check("R10 disable empties buffer", 32'(rx_status), 32'h0);
        check("R10 disable clears overflow", 32'(rx_overflow), 32'h0);
        setup(1, 0, 1, 1, 0, 1, 5'd15);
        send_word(32'hAAAA, 16, 1);
        cfg_en = 1'b0;
        wait_clk(2);
        cfg_en = 1'b1;
        wait_clk(2);
        send_word(32'h1111, 16, 1);
        check("R10 half pair discarded on disable", 32'(rx_status), 32'h0);
        send_word(32'h2222, 16, 1);
        check("R10 fresh pair after re-enable", rd_data, 32'h22221111);
        setup(1, 0, 1, 1, 0, 0, 5'd7);
        send_word(32'hF0, 4, 1);
        cfg_en = 1'b0;
        wait_clk(2);
        cfg_en = 1'b1;
        wait_clk(2);
        send_word(32'hC3, 8, 1);
        check("R10 partial word discarded", rd_data, 32'hC3);
    endtask

    initial begin
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_msb_late_rise();
        t_lsb_early_fall_low();
        t_lengths();
        t_no_fs_dropped();
        t_continuous();
        t_overflow();
        t_pack();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule